// File: doc/BRIEF.md
# Automatic Level Control Gain Sequencer

This block is the digital loop that picks the gain code for a programmable-gain amplifier ahead of an audio converter. On every sample strobe it compares the peak magnitude from the converter against a target. The gain moves down when the signal is too loud and up when it is too quiet. A hold timer delays each ramp-up. Separate attack and decay timers pace each move. An overload detector forces the fastest attack while the input sits near full scale.

Two modes share the loop. In automatic level control mode the gain is clamped between an absolute ceiling and an absolute floor, both decoded from register fields. In limiter mode the gain may only drop below a static programmed gain, by a bounded amount, and climbs back to that static gain. The output is a two's-complement gain code whose LSB is 0.25 dB. Every step moves the code by 3 LSB, which is 0.75 dB.

Top module: `alc_gain_seq`

## Requirements
- R1: While reset is asserted the gain code is 0. A load sets the gain code to staticGain and clears all timers. A load happens in every clock cycle in which alcEnable is low, in the cycle after alcEnable rises, and in the cycle after limiterMode changes. No step happens in a load cycle.
- R2: In level-control mode (limiterMode = 0) a step up saturates at a ceiling decoded from maxGainSel. Code 7 gives +24 dB (code 96), and each lower code is 4 dB lower, down to code 2 = +4 dB (16). Codes 1 and 0 both give 0 dB (0).
- R3: In level-control mode a step down saturates at a floor decoded from maxAttenSel. Codes 0 to 10 give -1 dB (-4). Code 11 gives -5 dB (-20), and each higher code is 4 dB lower, so 14 gives -17 dB and 15 gives -21 dB (-84).
- R4: In limiter mode the ceiling equals staticGain, and maxGainSel has no effect.
- R5: In limiter mode the floor is staticGain minus (3 + maxAttenSel) dB for codes 0 to 9. Codes above 9 act as 9, which is 12 dB below staticGain.
- R6: In level-control mode, after the peak drops to or below targetLevel, ramp-up waits for a hold count of strobes. For holdSel = n ≥ 1 the count is 128·2^(n-1) strobes; for n = 0 there is no wait. The first step-up may come on the strobe after the hold count. Any strobe with peak above target restarts the hold. Limiter mode has no hold.
- R7: When peakMag > targetLevel and there is no overload, the gain steps down by 3 on every 2^attackSel-th such strobe, with no hold delay.
- R8: When the peak is at or below target and the hold has elapsed, the gain steps up by 3 on every 2^decaySel-th strobe.
- R9: In level-control mode, a peakMag above 7/8 of full scale (above 7·2^(PW-3)) steps the gain down on every strobe, whatever attackSel holds. In limiter mode this override does not apply.
- R10: The gain code changes only on a sample strobe or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One-cycle pulse per audio sample |
| alcEnable | input | 1 | Loop enable; while low the gain holds staticGain |
| limiterMode | input | 1 | 1 = limiter, 0 = level control |
| peakMag | input | PW (16) | Unsigned peak magnitude of the current sample |
| targetLevel | input | PW (16) | Unsigned target magnitude |
| staticGain | input | GW (8) | Programmed gain, signed, 0.25 dB LSB |
| maxGainSel | input | 3 | Ceiling select, level-control mode |
| maxAttenSel | input | 4 | Floor / attenuation-depth select |
| holdSel | input | 4 | Hold time select |
| attackSel | input | 4 | Attack period select |
| decaySel | input | 4 | Decay period select |
| gainCode | output | GW (8) | Signed gain code, 0.25 dB LSB |

## Verification
The assertions assume that sampleStb is a pulse of one cycle. They also assume the register fields and staticGain are changed only between strobes, and that staticGain stays far enough above the bottom of the code range that the limiter floor can be represented. The stimulus drives every input on the falling clock edge. It changes fields only between strobes and keeps staticGain between 8 and 20. It includes gaps between strobes so that idle cycles can be observed.

// File: rtl/alc_pkg.sv
package alc_pkg;
  typedef struct packed {
    logic load;
    logic stepUp;
    logic stepDown;
  } alcStb_t;

  localparam int STEP_LSB = 3;
endpackage

// File: rtl/alc_ctrl.sv
module alc_ctrl
  import alc_pkg::*;
#(
  parameter int PW     = 16,
  parameter int HOLD_W = 22,
  parameter int RATE_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleStb,
  input  logic          alcEnable,
  input  logic          limiterMode,
  input  logic [PW-1:0] peakMag,
  input  logic [PW-1:0] targetLevel,
  input  logic [3:0]    holdSel,
  input  logic [3:0]    attackSel,
  input  logic [3:0]    decaySel,
  output alcStb_t       strobes
);
  localparam logic [PW-1:0] OVL_TH = PW'(7) << (PW - 3);

  logic              prevEn, prevMode;
  logic [HOLD_W-1:0] holdCnt, holdLim;
  logic [RATE_W-1:0] atkCnt, dcyCnt, atkTop, dcyTop;
  logic              overload, above, load, holdDone, atkDue, dcyDue;

  always_comb begin
    overload = !limiterMode && (peakMag > OVL_TH);
    above    = peakMag > targetLevel;
    load     = !alcEnable || !prevEn || (limiterMode != prevMode);
    if (limiterMode || holdSel == 4'd0) holdLim = '0;
    else holdLim = HOLD_W'(128) << (holdSel - 4'd1);
    holdDone = holdCnt >= holdLim;
    atkTop   = (RATE_W'(1) << attackSel) - RATE_W'(1);
    dcyTop   = (RATE_W'(1) << decaySel) - RATE_W'(1);
    atkDue   = atkCnt == atkTop;
    dcyDue   = dcyCnt == dcyTop;
    strobes.load     = load;
    strobes.stepDown = !load && sampleStb && (overload || (above && atkDue));
    strobes.stepUp   = !load && sampleStb && !overload && !above && holdDone && dcyDue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEn   <= 1'b0;
      prevMode <= 1'b0;
      holdCnt  <= '0;
      atkCnt   <= '0;
      dcyCnt   <= '0;
    end else begin
      prevEn   <= alcEnable;
      prevMode <= limiterMode;
      if (load) begin
        holdCnt <= '0;
        atkCnt  <= '0;
        dcyCnt  <= '0;
      end else if (sampleStb) begin
        if (overload) begin
          holdCnt <= '0;
          atkCnt  <= '0;
          dcyCnt  <= '0;
        end else if (above) begin
          holdCnt <= '0;
          dcyCnt  <= '0;
          atkCnt  <= atkDue ? '0 : atkCnt + RATE_W'(1);
        end else begin
          atkCnt <= '0;
          if (!holdDone) begin
            holdCnt <= holdCnt + HOLD_W'(1);
            dcyCnt  <= '0;
          end else begin
            dcyCnt <= dcyDue ? '0 : dcyCnt + RATE_W'(1);
          end
        end
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.stepUp, strobes.stepDown})); // R1
  AST_NO_STEP_OFF_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |-> !(strobes.stepUp || strobes.stepDown)); // R10
  AST_OVL_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && alcEnable && !limiterMode && peakMag > OVL_TH && !strobes.load)
      |-> strobes.stepDown); // R9
  AST_UP_ONLY_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepUp |-> (peakMag <= targetLevel)); // R6
endmodule

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  alcStb_t       strobes,
  input  logic          limiterMode,
  input  logic [GW-1:0] staticGain,
  input  logic [2:0]    maxGainSel,
  input  logic [3:0]    maxAttenSel,
  output logic [GW-1:0] gainCode
);
  localparam int EW = GW + 3;
  localparam logic signed [EW-1:0] MINV = -(EW'(1) << (GW - 1));

  logic signed [EW-1:0] gainExt, statExt, ceilV, floorV, floorRaw, upV, downV;
  logic [3:0]           attenClip;

  always_comb begin
    gainExt   = EW'($signed(gainCode));
    statExt   = EW'($signed(staticGain));
    attenClip = (maxAttenSel > 4'd9) ? 4'd9 : maxAttenSel;
    if (limiterMode) begin
      ceilV    = statExt;
      floorRaw = statExt - EW'(4) * (EW'(3) + EW'(attenClip));
    end else begin
      ceilV    = (maxGainSel <= 3'd1) ? '0 : EW'(16) * (EW'(maxGainSel) - EW'(1));
      floorRaw = (maxAttenSel <= 4'd10) ? -EW'(4)
               : -EW'(4) - EW'(16) * (EW'(maxAttenSel) - EW'(10));
    end
    floorV = (floorRaw < MINV) ? MINV : floorRaw;
    upV    = (gainExt + EW'(STEP_LSB) > ceilV) ? ceilV : gainExt + EW'(STEP_LSB);
    downV  = (gainExt - EW'(STEP_LSB) < floorV) ? floorV : gainExt - EW'(STEP_LSB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gainCode <= '0;
    else if (strobes.load)     gainCode <= staticGain;
    else if (strobes.stepDown) gainCode <= downV[GW-1:0];
    else if (strobes.stepUp)   gainCode <= upV[GW-1:0];
  end

  AST_LOAD_STATIC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> gainCode == $past(staticGain)); // R1
  AST_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepUp |=> EW'($signed(gainCode)) <= $past(ceilV)); // R2
  AST_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepDown |=> EW'($signed(gainCode)) >= $past(floorV)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.stepUp || strobes.stepDown) |=> $stable(gainCode)); // R10
endmodule

// File: rtl/alc_gain_seq.sv
module alc_gain_seq
  import alc_pkg::*;
#(
  parameter int PW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleStb,
  input  logic          alcEnable,
  input  logic          limiterMode,
  input  logic [PW-1:0] peakMag,
  input  logic [PW-1:0] targetLevel,
  input  logic [GW-1:0] staticGain,
  input  logic [2:0]    maxGainSel,
  input  logic [3:0]    maxAttenSel,
  input  logic [3:0]    holdSel,
  input  logic [3:0]    attackSel,
  input  logic [3:0]    decaySel,
  output logic [GW-1:0] gainCode
);
  alcStb_t strobes;

  alc_ctrl #(.PW(PW)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .alcEnable(alcEnable),
    .limiterMode(limiterMode), .peakMag(peakMag), .targetLevel(targetLevel),
    .holdSel(holdSel), .attackSel(attackSel), .decaySel(decaySel),
    .strobes(strobes)
  );

  alc_datapath #(.GW(GW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .limiterMode(limiterMode),
    .staticGain(staticGain), .maxGainSel(maxGainSel), .maxAttenSel(maxAttenSel),
    .gainCode(gainCode)
  );
endmodule

// File: tb/sim_alc_gain_seq.sv
`timescale 1ns/1ps
module sim_alc_gain_seq;
  localparam int PW = 16;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleStb = 1'b0, alcEnable = 1'b0, limiterMode = 1'b0;
  logic [PW-1:0] peakMag = '0, targetLevel = 16'd1000;
  logic [GW-1:0] staticGain = 8'd8;
  logic [2:0]    maxGainSel = 3'd7;
  logic [3:0]    maxAttenSel = 4'd6, holdSel = '0, attackSel = '0, decaySel = '0;
  logic [GW-1:0] gainCode;

  int nChecks = 0, nFails = 0, cycles = 0;
  string curReq = "R1";

  alc_gain_seq #(.PW(PW), .GW(GW)) u0 (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  int mG, mHold, mAtk, mDcy;
  bit mPrevEn, mPrevMode;

  function automatic int ceilOf();
    if (limiterMode) return $signed(staticGain);
    if (maxGainSel <= 1) return 0;
    return 16 * (int'(maxGainSel) - 1);
  endfunction

  function automatic int floorOf();
    int f, a;
    if (limiterMode) begin
      a = (maxAttenSel > 9) ? 9 : int'(maxAttenSel);
      f = $signed(staticGain) - 4 * (3 + a);
    end else if (maxAttenSel <= 10) f = -4;
    else f = -4 - 16 * (int'(maxAttenSel) - 10);
    return (f < -128) ? -128 : f;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mG = 0; mHold = 0; mAtk = 0; mDcy = 0; mPrevEn = 0; mPrevMode = 0;
    end else begin
      bit ld, ovl;
      int hl, c, f;
      ld = !alcEnable || !mPrevEn || (limiterMode != mPrevMode);
      mPrevEn = alcEnable; mPrevMode = limiterMode;
      c = ceilOf(); f = floorOf();
      if (ld) begin
        mG = $signed(staticGain); mHold = 0; mAtk = 0; mDcy = 0;
      end else if (sampleStb) begin
        ovl = !limiterMode && (peakMag > 16'hE000);
        if (ovl) begin
          mG = (mG - 3 < f) ? f : mG - 3; mHold = 0; mAtk = 0; mDcy = 0;
        end else if (peakMag > targetLevel) begin
          mHold = 0; mDcy = 0;
          if (mAtk == (1 << attackSel) - 1) begin mG = (mG - 3 < f) ? f : mG - 3; mAtk = 0; end
          else mAtk++;
        end else begin
          mAtk = 0;
          hl = (limiterMode || holdSel == 0) ? 0 : (128 << (holdSel - 1));
          if (mHold < hl) begin mHold++; mDcy = 0; end
          else if (mDcy == (1 << decaySel) - 1) begin mG = (mG + 3 > c) ? c : mG + 3; mDcy = 0; end
          else mDcy++;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      nChecks++;
      if (int'($signed(gainCode)) != mG) begin
        nFails++;
        $display("FAIL %s model compare: actual %0d expected %0d at %0t",
                 curReq, $signed(gainCode), mG, $time);
      end
    end
  end

  task automatic checkVal(input string req, input int expv);
    nChecks++;
    if (int'($signed(gainCode)) != expv) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, $signed(gainCode), expv);
    end
  endtask

  task automatic strobes(input int n, input int gap = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sampleStb = 1'b1;
      @(negedge clk) sampleStb = 1'b0;
      for (int j = 0; j < gap; j++) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    checkVal("R1", 0);                      // gain is 0 during reset
    rstN = 1'b1;
    idle(2);
    checkVal("R1", 8);                      // disabled: static gain

    // level-control ramp-up and ceilings
    curReq = "R2"; peakMag = 16'd100;
    alcEnable = 1'b1; idle(2);
    checkVal("R1", 8);
    strobes(40);                  checkVal("R2", 96);
    maxGainSel = 3'd2; strobes(1); checkVal("R2", 16);
    maxGainSel = 3'd0; strobes(1); checkVal("R2", 0);

    // attack and floors
    curReq = "R3"; peakMag = 16'd2000; attackSel = 4'd2;
    strobes(100);                  checkVal("R3", -4);
    maxAttenSel = 4'd11; strobes(100); checkVal("R3", -20);
    maxAttenSel = 4'd15; strobes(120); checkVal("R3", -84);

    // overload override
    curReq = "R9";
    @(negedge clk) alcEnable = 1'b0;
    @(negedge clk) alcEnable = 1'b1;
    idle(1);
    attackSel = 4'd5; peakMag = 16'hF000;
    strobes(10);                   checkVal("R9", -22);

    // limiter mode
    curReq = "R9"; staticGain = 8'd20; limiterMode = 1'b1; idle(2);
    checkVal("R1", 20);
    strobes(32);                   checkVal("R9", 17);
    curReq = "R5"; attackSel = 4'd0; maxAttenSel = 4'd2;
    strobes(20);                   checkVal("R5", 0);
    maxAttenSel = 4'd12; strobes(20); checkVal("R5", -28);
    curReq = "R4"; peakMag = 16'd100; decaySel = 4'd1; maxGainSel = 3'd0;
    strobes(40);                   checkVal("R4", 20);

    // hold timer
    curReq = "R6"; limiterMode = 1'b0; idle(2);
    maxGainSel = 3'd7; maxAttenSel = 4'd15; attackSel = 4'd0; peakMag = 16'd2000;
    strobes(10);                   checkVal("R6", -10);
    peakMag = 16'd100; holdSel = 4'd1; decaySel = 4'd0;
    strobes(128);                  checkVal("R6", -10);
    strobes(1);                    checkVal("R6", -7);
    peakMag = 16'd2000; strobes(1); checkVal("R7", -10);
    peakMag = 16'd100; strobes(128); checkVal("R6", -10);
    strobes(1);                    checkVal("R6", -7);

    // attack period
    curReq = "R7"; holdSel = 4'd0; attackSel = 4'd3; peakMag = 16'd2000;
    strobes(7);                    checkVal("R7", -7);
    strobes(1);                    checkVal("R7", -10);

    // decay period
    curReq = "R8"; decaySel = 4'd2; peakMag = 16'd100;
    strobes(3);                    checkVal("R8", -10);
    strobes(1);                    checkVal("R8", -7);

    // strobes with idle gaps
    curReq = "R10"; decaySel = 4'd0;
    strobes(5, 2);                 checkVal("R10", 8);
    idle(6);                       checkVal("R10", 8);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule